// File: doc/BRIEF.md
# Decimal Digit Adder with Seven-Segment Output

This block adds two decimal digits and shows the operands and their sum on four seven-segment displays. Each operand arrives as a 4-bit binary-coded decimal value that the block may assume lies between 0 and 9. The sum, 0 to 18, is split into a tens digit and a units digit. Each of the four digits is then turned into a segment pattern by its own copy of a shared digit-to-segment encoder.

The block is purely combinational. It has no clock, no registers and no held state, so every output follows its inputs in the same cycle. The segment outputs are active low, for common-anode displays. The tens display always shows a digit, so a sum below ten appears with a leading 0.

Top module: `bcd_sum_display`

## Requirements
- R1: `seg_op_a` shows the digit on `op_a` for every value 0 to 9.
- R2: `seg_op_b` shows the digit on `op_b` for every value 0 to 9.
- R3: `seg_units` shows S when the binary sum S = op_a + op_b is below 10, and S - 10 otherwise.
- R4: `seg_tens` shows 1 when S is 10 or more and shows 0 (not blank) when S is below 10.
- R5: Segments are active low, with bit 6 down to bit 0 being segments g,f,e,d,c,b,a. The digit codes are 0=7'h40, 1=7'h79, 2=7'h24, 3=7'h30, 4=7'h19, 5=7'h12, 6=7'h02, 7=7'h78, 8=7'h00 and 9=7'h10.
- R6: The block holds no state. All four outputs take their new values in the same cycle that the inputs change, for every ordering of input changes.
- R7: The carry boundary is exact: 9+0 shows 09, 9+1 and 1+9 show 10, and 9+9 shows 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First decimal operand, 0 to 9 |
| op_b | input | 4 | Second decimal operand, 0 to 9 |
| seg_op_a | output | 7 | Active-low segments echoing op_a |
| seg_op_b | output | 7 | Active-low segments echoing op_b |
| seg_tens | output | 7 | Active-low segments for the tens digit of the sum |
| seg_units | output | 7 | Active-low segments for the units digit of the sum |

## Verification
Whenever both operands are valid digits, the bound checker decodes the four segment patterns back into numbers. It confirms that the echoed digits match the operands, that ten times the tens digit plus the units digit equals the operand sum, and that the tens digit is only 0 or 1. It cannot show that a particular segment code matches the intended glyph, because its decoder could share a mistake with the encoder. That, along with the exact carry boundary and the same-cycle response to a sweep of all 100 operand pairs, is shown only by the bench scoreboard, which compares against fixed codes written from the requirements.

// File: rtl/bcd_sum_display_pkg.sv
package bcd_sum_display_pkg;
  localparam int DIGIT_W  = 4;
  localparam int SEG_W    = 7;
  localparam int NUM_DISP = 4;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  // Display slot order inside the top module's digit array.
  typedef enum logic [1:0] {
    DISP_OP_A  = 2'd0,
    DISP_OP_B  = 2'd1,
    DISP_TENS  = 2'd2,
    DISP_UNITS = 2'd3
  } disp_idx_e;
endpackage

// File: rtl/bcd_digit_add.sv
// Adds two decimal digits and splits the result into tens and units.
module bcd_digit_add #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] add_a,
  input  logic [DIGIT_W-1:0] add_b,
  output logic [DIGIT_W-1:0] tens,
  output logic [DIGIT_W-1:0] units
);
  localparam int SUM_W = DIGIT_W + 1;

  logic [SUM_W-1:0] bin_sum;
  logic             carry_dec;

  always_comb begin
    bin_sum   = SUM_W'(add_a) + SUM_W'(add_b);
    carry_dec = (bin_sum > SUM_W'(9));
    if (carry_dec) begin
      units = DIGIT_W'(bin_sum - SUM_W'(10));
      tens  = DIGIT_W'(1);
    end else begin
      units = DIGIT_W'(bin_sum);
      tens  = '0;
    end
  end
endmodule

// File: rtl/seg7_encode.sv
// Turns one 4-bit digit into a segment pattern {g,f,e,d,c,b,a}.
module seg7_encode #(
  parameter int DIGIT_W    = 4,
  parameter int SEG_W      = 7,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [DIGIT_W-1:0] digit,
  output logic [SEG_W-1:0]   seg
);
  logic [6:0] lit;  // 1 = segment on

  always_comb begin
    case (digit[3:0])
      4'h0:    lit = 7'b0111111;
      4'h1:    lit = 7'b0000110;
      4'h2:    lit = 7'b1011011;
      4'h3:    lit = 7'b1001111;
      4'h4:    lit = 7'b1100110;
      4'h5:    lit = 7'b1101101;
      4'h6:    lit = 7'b1111101;
      4'h7:    lit = 7'b0000111;
      4'h8:    lit = 7'b1111111;
      4'h9:    lit = 7'b1101111;
      4'hA:    lit = 7'b1110111;
      4'hB:    lit = 7'b1111100;
      4'hC:    lit = 7'b0111001;
      4'hD:    lit = 7'b1011110;
      4'hE:    lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg = SEG_W'(~lit);
    end else begin : g_high
      assign seg = SEG_W'(lit);
    end
  endgenerate
endmodule

// File: rtl/bcd_sum_display.sv
module bcd_sum_display
  import bcd_sum_display_pkg::*;
#(
  parameter int W_DIG = DIGIT_W,
  parameter int W_SEG = SEG_W
) (
  input  logic [W_DIG-1:0] op_a,
  input  logic [W_DIG-1:0] op_b,
  output logic [W_SEG-1:0] seg_op_a,
  output logic [W_SEG-1:0] seg_op_b,
  output logic [W_SEG-1:0] seg_tens,
  output logic [W_SEG-1:0] seg_units
);
  logic [W_DIG-1:0] sum_tens;
  logic [W_DIG-1:0] sum_units;
  logic [W_DIG-1:0] disp_digit [NUM_DISP];
  logic [W_SEG-1:0] disp_seg   [NUM_DISP];

  bcd_digit_add #(.DIGIT_W(W_DIG)) u_add (
    .add_a (op_a),
    .add_b (op_b),
    .tens  (sum_tens),
    .units (sum_units)
  );

  assign disp_digit[DISP_OP_A]  = op_a;
  assign disp_digit[DISP_OP_B]  = op_b;
  assign disp_digit[DISP_TENS]  = sum_tens;
  assign disp_digit[DISP_UNITS] = sum_units;

  for (genvar gi = 0; gi < NUM_DISP; gi++) begin : g_disp
    seg7_encode #(
      .DIGIT_W    (W_DIG),
      .SEG_W      (W_SEG),
      .ACTIVE_LOW (1'b1)
    ) u_enc (
      .digit (disp_digit[gi]),
      .seg   (disp_seg[gi])
    );
  end

  assign seg_op_a  = disp_seg[DISP_OP_A];
  assign seg_op_b  = disp_seg[DISP_OP_B];
  assign seg_tens  = disp_seg[DISP_TENS];
  assign seg_units = disp_seg[DISP_UNITS];
endmodule

// File: rtl/bcd_sum_display_chk.sv
module bcd_sum_display_chk (
  input logic [3:0] op_a,
  input logic [3:0] op_b,
  input logic [6:0] seg_op_a,
  input logic [6:0] seg_op_b,
  input logic [6:0] seg_tens,
  input logic [6:0] seg_units
);
  // Reads a pattern back into a number. Unknown patterns give 99.
  function automatic int seg_value(input logic [6:0] s);
    logic [6:0] on;
    on = ~s;
    if      (on == 7'b0111111) return 0;
    else if (on == 7'b0000110) return 1;
    else if (on == 7'b1011011) return 2;
    else if (on == 7'b1001111) return 3;
    else if (on == 7'b1100110) return 4;
    else if (on == 7'b1101101) return 5;
    else if (on == 7'b1111101) return 6;
    else if (on == 7'b0000111) return 7;
    else if (on == 7'b1111111) return 8;
    else if (on == 7'b1101111) return 9;
    else return 99;
  endfunction

  always_comb begin
    if (!$isunknown({op_a, op_b}) && op_a < 4'd10 && op_b < 4'd10) begin
      a_r1_echo_a: assert (seg_value(seg_op_a) == int'(op_a))
        else $error("a_r1_echo_a: operand a display mismatch");
      a_r2_echo_b: assert (seg_value(seg_op_b) == int'(op_b))
        else $error("a_r2_echo_b: operand b display mismatch");
      a_r3_sum_value: assert (10 * seg_value(seg_tens) + seg_value(seg_units)
                              == int'(op_a) + int'(op_b))
        else $error("a_r3_sum_value: displayed sum mismatch");
      a_r4_tens_range: assert (seg_value(seg_tens) <= 1)
        else $error("a_r4_tens_range: tens digit out of range");
    end
  end
endmodule

bind bcd_sum_display bcd_sum_display_chk u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .seg_op_a  (seg_op_a),
  .seg_op_b  (seg_op_b),
  .seg_tens  (seg_tens),
  .seg_units (seg_units)
);

// File: tb/bcd_sum_display_bench.sv
module bcd_sum_display_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic [6:0] seg_op_a, seg_op_b, seg_tens, seg_units;

  bcd_sum_display u_bcd_sum_display (
    .op_a      (op_a),
    .op_b      (op_b),
    .seg_op_a  (seg_op_a),
    .seg_op_b  (seg_op_b),
    .seg_tens  (seg_tens),
    .seg_units (seg_units)
  );

  typedef struct packed {
    logic [6:0] ea;
    logic [6:0] eb;
    logic [6:0] et;
    logic [6:0] eu;
    logic [3:0] a;
    logic [3:0] b;
  } item_t;

  item_t expq[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Codes from R5 (active low, {g,f,e,d,c,b,a}).
  function automatic logic [6:0] code_of(input int d);
    case (d)
      0: return 7'h40;
      1: return 7'h79;
      2: return 7'h24;
      3: return 7'h30;
      4: return 7'h19;
      5: return 7'h12;
      6: return 7'h02;
      7: return 7'h78;
      8: return 7'h00;
      default: return 7'h10;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp_v,
                       input logic [3:0] a, input logic [3:0] b);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", req, a, b, act, exp_v);
    end
  endtask

  // Driver: apply a pair, push its expected displays.
  task automatic drive(input int a, input int b);
    item_t it;
    int s;
    s = a + b;
    it.a  = 4'(a);
    it.b  = 4'(b);
    it.ea = code_of(a);
    it.eb = code_of(b);
    it.et = code_of((s > 9) ? 1 : 0);
    it.eu = code_of((s > 9) ? s - 10 : s);
    @(posedge clk);
    op_a = 4'(a);
    op_b = 4'(b);
    expq.push_back(it);
  endtask

  // Monitor: same-cycle result (R6), sampled at the falling edge.
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      item_t it;
      it = expq.pop_front();
      check("R1", seg_op_a,  it.ea, it.a, it.b);
      check("R2", seg_op_b,  it.eb, it.a, it.b);
      check("R4", seg_tens,  it.et, it.a, it.b);
      check("R3", seg_units, it.eu, it.a, it.b);
      // R6: one item per cycle, so a stale output would mismatch here.
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset-time state with both operands zero: every display shows 0 (R5).
    check("R5", seg_op_a,  7'h40, op_a, op_b);
    check("R5", seg_tens,  7'h40, op_a, op_b);
    check("R5", seg_units, 7'h40, op_a, op_b);
    rst = 1'b0;

    // R7 boundary pairs first.
    drive(9, 0);
    drive(9, 1);
    drive(1, 9);
    drive(9, 9);
    drive(5, 5);
    drive(0, 0);

    // Full sweep of all 100 valid pairs, row order then column order (R6).
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        drive(i, j);
    for (int j = 0; j < 10; j++)
      for (int i = 9; i >= 0; i--)
        drive(i, j);

    @(posedge clk);
    @(posedge clk);
    if (expq.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R6 queue not drained actual=%0d expected=0", expq.size());
    end
    finish_run();
  end
endmodule